// File: doc/BRIEF.md
# I2C Bit-Level Command Engine with Bus Recovery

This block is the master side of an I2C link at the bit level. It takes one command at a time from a controller: generate a start condition, generate a stop condition, send a byte and collect the acknowledge, receive a byte and answer it with an acknowledge or a not-acknowledge, or run a bus recovery sequence. It reports the end of each command with a one-cycle pulse. Sequencing commands into whole transfers is left to the controller.

All bus timing is built from one unit, a quarter of an SCL period. The length of a unit in system clocks is set on an input. SCL is driven as a plain output. SDA is open-drain: the engine only asserts an enable that pulls the wire low, and otherwise leaves it released. The returned SDA level passes through a synchronizer before the engine samples it.

The recovery command clocks nine pulses with SDA released, then issues a stop. This frees a slave that was left holding SDA low in the middle of a byte.

Top module: `i2c_bitseq`

## Requirements
- R1: After reset, `scl_o` is 1, `sda_oe` is 0, and `busy` and `done` are 0.
- R2: One unit lasts `quarter_div`+1 clocks. `done` pulses high for exactly one cycle (U+1)*(quarter_div+1) clocks after the accepting edge, where U+1 is the number of units the command lasts: START 3, STOP 4, WRITE 37, READ 37, RECOVER 40. `busy` is 1 from the accepting edge and returns to 0 in the same cycle that `done` rises.
- R3: A command is accepted only while `busy` is 0. A `cmd_valid` seen while busy changes neither the timing nor the result of the running command. A command presented in the cycle in which `done` is high is accepted.
- R4: START (`cmd_op`=0) releases SDA, raises SCL, then pulls SDA low while SCL is high. It ends with `scl_o`=1 and `sda_oe`=1, and no stop condition appears.
- R5: STOP (`cmd_op`=1) lowers SCL, pulls SDA low, raises SCL, then releases SDA while SCL is high. It ends with `scl_o`=1 and `sda_oe`=0.
- R6: WRITE (`cmd_op`=2) sends `cmd_wdata` MSB first on eight SCL rising edges. During the command SDA never changes while SCL stays high. It ends with `scl_o`=0 and `sda_oe`=0.
- R7: After the eighth bit of a WRITE, SDA is released for a ninth clock. `ack_level` returns the SDA level sampled at the end of that clock's high phase: 0 means acknowledge, 1 means not-acknowledge.
- R8: READ (`cmd_op`=3) keeps SDA released for eight clocks. It samples each bit one unit after SCL rises and presents the byte MSB first on `rdata` once `done` is high.
- R9: On the ninth clock of a READ, SDA is pulled low when `cmd_nack`=0 and released when `cmd_nack`=1. That level stays in place through both high units, and it is still on `sda_oe` when the command ends.
- R10: RECOVER (`cmd_op`=4) gives nine SCL high pulses, each two units low and two units high, with SDA released, and then a stop. That is ten rising edges in all and exactly one stop condition. It ends with `scl_o`=1 and `sda_oe`=0.
- R11: Operation codes 5 to 7 are never accepted. `busy` stays 0 and the bus lines do not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| quarter_div | input | DIV_W | Clocks per quarter-bit unit, minus one |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Operation: 0 START, 1 STOP, 2 WRITE, 3 READ, 4 RECOVER |
| cmd_wdata | input | 8 | Byte to send for WRITE |
| cmd_nack | input | 1 | READ answer: 0 acknowledge, 1 not-acknowledge |
| busy | output | 1 | A command is running |
| done | output | 1 | One-cycle pulse when a command finishes |
| rdata | output | 8 | Byte received by the last READ |
| ack_level | output | 1 | SDA level sampled in the acknowledge slot of the last WRITE |
| scl_o | output | 1 | SCL level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_i | input | 1 | Level present on the SDA wire |

## Verification
Two things can coincide in one cycle: the completion pulse of one command and the request for the next. A command arriving during that cycle must start a new sequence cleanly.

The bench produces this overlap with zero-gap runs, where the next request is raised while `done` is high. It also pulses `cmd_valid` in the middle of a running command. A slave model on the bus supplies acknowledge levels and read bytes. Each command is then judged at the ports by its measured length, the bus events it produced and the data it returned, against values computed from the requirements.

// File: rtl/i2c_bitseq_pkg.sv
`timescale 1ns / 1ps
package i2c_bitseq_pkg;

    localparam int UNIT_W = 6;

    typedef enum logic [2:0] {
        OP_START   = 3'd0,
        OP_STOP    = 3'd1,
        OP_WRITE   = 3'd2,
        OP_READ    = 3'd3,
        OP_RECOVER = 3'd4
    } op_e;

    // Last unit index of each command
    localparam logic [UNIT_W-1:0] START_LAST   = 6'd2;
    localparam logic [UNIT_W-1:0] STOP_LAST    = 6'd3;
    localparam logic [UNIT_W-1:0] BYTE_LAST    = 6'd36;
    localparam logic [UNIT_W-1:0] PULSE_UNITS  = 6'd36;   // nine pulses x four units
    localparam logic [UNIT_W-1:0] RECOVER_LAST = 6'd39;
    localparam logic [UNIT_W-1:0] ACK_SAMPLE   = 6'd35;

    typedef struct packed {
        logic scl;   // 1 = SCL high
        logic oe;    // 1 = SDA pulled low
    } line_t;

    function automatic logic op_valid(input logic [2:0] code);
        return code <= 3'd4;
    endfunction

    function automatic logic [UNIT_W-1:0] last_unit(input op_e op);
        case (op)
            OP_START:           return START_LAST;
            OP_STOP:            return STOP_LAST;
            OP_WRITE, OP_READ:  return BYTE_LAST;
            default:            return RECOVER_LAST;
        endcase
    endfunction

    // Line levels to apply at the start of unit u
    function automatic line_t unit_drive(input op_e op, input logic [UNIT_W-1:0] u,
                                         input logic [7:0] wdata, input logic nack,
                                         input line_t cur);
        line_t      r;
        logic [3:0] slot;
        logic [1:0] ph;
        logic [5:0] tail;
        r    = cur;
        slot = u[5:2];
        ph   = u[1:0];
        tail = u - PULSE_UNITS;
        case (op)
            OP_START: begin
                case (u)
                    6'd0:    r.oe  = 1'b0;
                    6'd1:    r.scl = 1'b1;
                    6'd2:    r.oe  = 1'b1;
                    default: ;
                endcase
            end
            OP_STOP: begin
                case (u)
                    6'd0:    r.scl = 1'b0;
                    6'd1:    r.oe  = 1'b1;
                    6'd2:    r.scl = 1'b1;
                    6'd3:    r.oe  = 1'b0;
                    default: ;
                endcase
            end
            OP_WRITE, OP_READ: begin
                if (u == BYTE_LAST) begin
                    r.scl = 1'b0;
                end else begin
                    r.scl = ph[1];
                    if (slot < 4'd8) begin
                        if (op == OP_READ) begin
                            if (ph == 2'd0) r.oe = 1'b0;
                        end else if (ph == 2'd1) begin
                            r.oe = ~wdata[3'd7 - slot[2:0]];
                        end
                    end else if (ph == 2'd1) begin
                        r.oe = (op == OP_READ) ? ~nack : 1'b0;
                    end
                end
            end
            default: begin
                if (u < PULSE_UNITS) begin
                    r.scl = ph[1];
                    r.oe  = 1'b0;
                end else begin
                    case (tail)
                        6'd0:    r.scl = 1'b0;
                        6'd1:    r.oe  = 1'b1;
                        6'd2:    r.scl = 1'b1;
                        default: r.oe  = 1'b0;
                    endcase
                end
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bitseq_tick.sv
`timescale 1ns / 1ps
module bitseq_tick #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [DIV_W-1:0] limit,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || restart || tick) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/bitseq_sync.sv
`timescale 1ns / 1ps
module bitseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) pipe <= '1;
                else     pipe <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) pipe <= '1;
                else     pipe <= {pipe[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2c_bitseq.sv
`timescale 1ns / 1ps
module i2c_bitseq
    import i2c_bitseq_pkg::*;
#(
    parameter int DIV_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] quarter_div,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [7:0]       cmd_wdata,
    input  logic             cmd_nack,
    output logic             busy,
    output logic             done,
    output logic [7:0]       rdata,
    output logic             ack_level,
    output logic             scl_o,
    output logic             sda_oe,
    input  logic             sda_i
);
    logic              accept;
    logic              tick;
    logic              sda_s;
    op_e               op_q;
    logic [7:0]        wdata_q;
    logic              nack_q;
    logic [UNIT_W-1:0] ucnt;
    logic [UNIT_W-1:0] unext;
    line_t             line_q;
    logic [7:0]        shreg;
    logic              read_sample;

    assign accept      = cmd_valid && !busy && op_valid(cmd_op);
    assign unext       = ucnt + 6'd1;
    assign read_sample = (op_q == OP_READ) && (ucnt[5:2] < 4'd8) && (ucnt[1:0] == 2'd2);
    assign scl_o       = line_q.scl;
    assign sda_oe      = line_q.oe;

    bitseq_tick #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .restart (accept),
        .limit   (quarter_div),
        .tick    (tick)
    );

    bitseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (sda_i),
        .q   (sda_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            done      <= 1'b0;
            op_q      <= OP_START;
            wdata_q   <= '0;
            nack_q    <= 1'b0;
            ucnt      <= '0;
            line_q    <= '{scl: 1'b1, oe: 1'b0};
            shreg     <= '0;
            rdata     <= '0;
            ack_level <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                op_q    <= op_e'(cmd_op);
                wdata_q <= cmd_wdata;
                nack_q  <= cmd_nack;
                ucnt    <= '0;
                busy    <= 1'b1;
                line_q  <= unit_drive(op_e'(cmd_op), '0, cmd_wdata, cmd_nack, line_q);
            end else if (busy && tick) begin
                if (read_sample) shreg <= {shreg[6:0], sda_s};
                if (op_q == OP_WRITE && ucnt == ACK_SAMPLE) ack_level <= sda_s;
                if (ucnt == last_unit(op_q)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    if (op_q == OP_READ) rdata <= shreg;
                end else begin
                    ucnt   <= unext;
                    line_q <= unit_drive(op_q, unext, wdata_q, nack_q, line_q);
                end
            end
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                                     // R2
    AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);                                               // R2
    AST_UNIT_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy |-> (ucnt <= last_unit(op_q)));                                 // R2
    AST_BUSY_HOLDS_OP: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(op_q));                                             // R3
    AST_BYTE_SDA_QUIET: assert property (@(posedge clk) disable iff (rst)
        (busy && (op_q == OP_WRITE || op_q == OP_READ) && scl_o && $past(scl_o))
            |-> $stable(sda_oe));                                            // R6
    AST_RECOVER_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (busy && op_q == OP_RECOVER && ucnt < PULSE_UNITS) |-> !sda_oe);     // R10
    AST_BAD_OP_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!busy && cmd_valid && !op_valid(cmd_op)) |=> !busy);                // R11
endmodule

// File: tb/sim_i2c_bitseq.sv
`timescale 1ns / 1ps
module sim_i2c_bitseq;
    localparam int DIV_W = 12;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [DIV_W-1:0] quarter_div = 12'd1;
    logic             cmd_valid = 1'b0;
    logic [2:0]       cmd_op = 3'd0;
    logic [7:0]       cmd_wdata = 8'd0;
    logic             cmd_nack = 1'b0;
    logic             busy, done, ack_level, scl_o, sda_oe, sda_i;
    logic [7:0]       rdata;

    logic             slave_low = 1'b0;
    logic             sda_bus;
    assign sda_bus = !(sda_oe || slave_low);
    assign sda_i   = sda_bus;

    always #2.5 clk = ~clk;

    i2c_bitseq #(.DIV_W(DIV_W)) u0 (
        .clk(clk), .rst(rst), .quarter_div(quarter_div), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_wdata(cmd_wdata), .cmd_nack(cmd_nack),
        .busy(busy), .done(done), .rdata(rdata), .ack_level(ack_level),
        .scl_o(scl_o), .sda_oe(sda_oe), .sda_i(sda_i)
    );

    int checks = 0;
    int errors = 0;

    // bus observer and slave model
    int       mode = 0;          // 0 none, 1 acknowledging receiver, 2 byte source
    logic     ack_choice = 1'b0;
    logic [7:0] src_byte = 8'd0;
    int       rises = 0, starts = 0, stops = 0, high_rises = 0, quiet_viol = 0;
    logic [7:0] cap = 8'd0;
    logic     ninth = 1'b0;
    logic     prev_scl = 1'b1, prev_bus = 1'b1;
    logic     byte_op = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (scl_o && !prev_scl) begin
                if (rises < 8) cap = {cap[6:0], sda_bus};
                if (rises == 8) ninth = sda_bus;
                if (sda_bus) high_rises++;
                rises++;
            end
            if (scl_o && prev_scl && prev_bus && !sda_bus) starts++;
            if (scl_o && prev_scl && !prev_bus && sda_bus) stops++;
            if (byte_op && scl_o && prev_scl && (sda_bus != prev_bus)) quiet_viol++;
            if (!scl_o) begin
                if (mode == 1) slave_low = (rises == 8) && ack_choice;
                else if (mode == 2) slave_low = (rises < 8) && !src_byte[7 - rises];
                else slave_low = 1'b0;
            end
        end
        prev_scl = scl_o;
        prev_bus = sda_bus;
    end

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int units_of(input int op);
        case (op)
            0: return 3;
            1: return 4;
            2, 3: return 37;
            default: return 40;
        endcase
    endfunction

    // issue a command; gap = idle cycles before it (0 = during previous done cycle)
    task automatic run_cmd(input int op, input logic [7:0] wd, input logic nk,
                           input logic ackc, input logic [7:0] sb, input int gap,
                           input logic inject);
        int exp_cyc;
        int n;
        int inj_at;
        repeat (gap) begin @(posedge clk); #1; end
        rises = 0; starts = 0; stops = 0; high_rises = 0; quiet_viol = 0;
        cap = 8'd0; ninth = 1'b0;
        ack_choice = ackc; src_byte = sb;
        mode = (op == 2) ? 1 : (op == 3) ? 2 : 0;
        byte_op = (op == 2) || (op == 3);
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_wdata = wd; cmd_nack = nk;
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        exp_cyc = units_of(op) * (int'(quarter_div) + 1);
        inj_at  = 1 + int'($urandom_range(0, 3));
        n = 0;
        while (!done && n < exp_cyc + 20) begin
            if (inject && n == inj_at) begin
                cmd_valid = 1'b1; cmd_op = 3'd4 - 3'(op % 4); cmd_wdata = ~wd; cmd_nack = ~nk;
            end else begin
                cmd_valid = 1'b0;
            end
            @(posedge clk); #1;
            n++;
        end
        cmd_valid = 1'b0;
        chk(n == exp_cyc, inject ? "R3" : "R2", "command length", n, exp_cyc);
        chk(!busy, "R2", "busy low with done", int'(busy), 0);
        case (op)
            0: begin
                chk(starts == 1 && stops == 0, "R4", "start events", starts * 10 + stops, 10);
                chk(scl_o && sda_oe, "R4", "end lines", {scl_o, sda_oe}, 3);
            end
            1: begin
                chk(stops == 1, "R5", "stop events", stops, 1);
                chk(scl_o && !sda_oe, "R5", "end lines", {scl_o, sda_oe}, 2);
            end
            2: begin
                chk(cap == wd, "R6", "byte on bus", cap, wd);
                chk(quiet_viol == 0 && rises == 9, "R6", "sda moves/rises", quiet_viol * 100 + rises, 9);
                chk(!scl_o && !sda_oe, "R6", "end lines", {scl_o, sda_oe}, 0);
                chk(ack_level == !ackc, "R7", "ack level", int'(ack_level), int'(!ackc));
            end
            3: begin
                chk(rdata == sb, "R8", "read byte", rdata, sb);
                chk(quiet_viol == 0, "R8", "sda moves in high", quiet_viol, 0);
                chk(ninth == nk, "R9", "ninth bit level", int'(ninth), int'(nk));
                chk(sda_oe == !nk && !scl_o, "R9", "end oe", int'(sda_oe), int'(!nk));
            end
            default: begin
                chk(rises == 10 && high_rises == 9, "R10", "rises/released",
                    rises * 100 + high_rises, 1009);
                chk(stops == 1 && starts == 0, "R10", "stop/start events", stops * 10 + starts, 10);
                chk(scl_o && !sda_oe, "R10", "end lines", {scl_o, sda_oe}, 2);
            end
        endcase
        mode = 0; byte_op = 1'b0; slave_low = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int prev_op;
        void'($urandom(32'h51A7));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(posedge clk); #1;
        chk(scl_o && !sda_oe && !busy && !done, "R1", "reset state",
            {scl_o, sda_oe, busy, done}, 8);

        quarter_div = 12'd3;
        run_cmd(4, 8'h00, 1'b0, 1'b0, 8'h00, 1, 1'b0);
        run_cmd(0, 8'h00, 1'b0, 1'b0, 8'h00, 0, 1'b0);
        run_cmd(2, 8'hA5, 1'b0, 1'b1, 8'h00, 0, 1'b0);
        run_cmd(2, 8'h00, 1'b0, 1'b0, 8'h00, 2, 1'b1);
        quarter_div = 12'd1;
        run_cmd(2, 8'hFF, 1'b0, 1'b1, 8'h00, 0, 1'b0);
        run_cmd(0, 8'h00, 1'b0, 1'b0, 8'h00, 1, 1'b0);
        run_cmd(3, 8'h00, 1'b0, 1'b0, 8'h3C, 0, 1'b0);
        run_cmd(3, 8'h00, 1'b1, 1'b0, 8'h81, 3, 1'b1);
        run_cmd(1, 8'h00, 1'b0, 1'b0, 8'h00, 0, 1'b0);

        // R11: reserved operation codes
        for (int c = 5; c < 8; c++) begin
            cmd_valid = 1'b1; cmd_op = 3'(c);
            @(posedge clk); #1;
            cmd_valid = 1'b0;
            repeat (3) begin @(posedge clk); #1; end
            chk(!busy && scl_o && !sda_oe, "R11", "reserved op ignored",
                {busy, scl_o, sda_oe}, 2);
        end

        prev_op = 1;
        for (int i = 0; i < 40; i++) begin
            int op;
            op = int'($urandom_range(0, 4));
            if (prev_op == 0 && (op == 0 || op == 4)) op = 2;
            quarter_div = 12'($urandom_range(1, 4));
            run_cmd(op, 8'($urandom), 1'($urandom), 1'($urandom), 8'($urandom),
                    int'($urandom_range(0, 2)), 1'($urandom));
            prev_op = op;
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule